// File: doc/BRIEF.md
# Multiplexed-Bus Word Read Sequencer

This block is the processor-side controller that fetches one 16-bit word over a shared 8-bit bus on which address bytes and data bytes travel on the same wires. A user request supplies an address and a pointer choice: the data pointer, which must be given an even address, or the program pointer. The sequencer takes the bus, sends the address one byte at a time, marking each byte with a single-cycle active-low strobe, and then hands the bus to memory.

The hand-over is made by one ownership level rather than by separate read and write enables. Raising that level both releases the bus to memory and acts as the read enable. After one turnaround cycle the sequencer samples the low data byte, gives one more strobe, samples the high data byte, and reports the word with a one-cycle done pulse. It then drops the ownership level and returns to idle. A data-pointer request with an odd address is refused with a one-cycle error pulse, and no transfer starts.

Top module: `mbus_read_seq`

## Requirements
- R1: In idle, and out of reset, `strobeN` is 1, `memOwn` is 0, `busOe` is 0, `busy` is 0 and `ptrSel` is 0.
- R2: An accepted request raises `busy` on the next rising edge, and `busy` stays 1 through the cycle in which `done` is high.
- R3: During a transfer, `ptrSel` equals the latched `reqSel` (0 selects the data pointer, 1 selects the program pointer).
- R4: `memOwn` is 0 whenever `busOe` is 1. The low address byte (bits 7:0) is driven for one setup cycle and then one cycle with `strobeN` low. The high address byte (bits 15:8) follows in the same two-cycle pattern.
- R5: `memOwn` rises, and `busOe` falls, in the cycle right after the second address strobe. That cycle is a turnaround cycle with no strobe and no sampling.
- R6: The low data byte is sampled in the cycle after the turnaround. One `strobeN` low cycle follows, and then the high byte is sampled. Every strobe lasts exactly one cycle, and each transfer has exactly three strobes.
- R7: `done` is high for exactly one cycle. The state that drives it is reached on the ninth rising edge, counting the edge that samples the request as the first. `rdData` then holds `{high byte, low byte}` and keeps that value until the next transfer.
- R8: A request with `reqSel`=0 and `reqAddr[0]`=1 produces a one-cycle `addrErr` pulse on the next cycle, and no transfer, strobe or `busy` follows. Odd addresses with `reqSel`=1 are accepted.
- R9: `reqValid` is ignored while `busy` is 1.
- R10: In the cycle after `done`, `memOwn` is 0 and the block is idle and ready for a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request, sampled in idle |
| reqAddr | input | 16 | Word address |
| reqSel | input | 1 | 0 = data pointer, 1 = program pointer |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Word read |
| addrErr | output | 1 | One-cycle pulse for a refused odd data-pointer address |
| busOut | output | 8 | Byte driven toward memory |
| busOe | output | 1 | Output enable for `busOut` |
| busIn | input | 8 | Byte driven by memory |
| memOwn | output | 1 | Bus ownership level: 1 gives the bus to memory |
| ptrSel | output | 1 | Memory pointer select |
| strobeN | output | 1 | Active-low byte strobe |

## Verification
The hardest case to reach from the ports is a wrong sampling instant. A design that samples before the turnaround, or before the data strobe, would still see plausible bytes from a memory that answers too eagerly. The bench memory model therefore drives a fixed junk byte whenever it does not own the bus, and switches to the high byte only after it has seen a strobe while it owns the bus, so any off-by-one in sampling corrupts the word. A request pulsed in the middle of a transfer, and odd addresses on both pointers, exercise the acceptance rules.

// File: rtl/mbrd_pkg.sv
package mbrd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ALO,
    ST_ALO_STB,
    ST_AHI,
    ST_AHI_STB,
    ST_TURN,
    ST_DLO,
    ST_DSTB,
    ST_DHI,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic       loadReq;
    logic       driveBus;
    logic       addrHi;
    logic [1:0] capLane;
  } seqCtl_t;

endpackage

// File: rtl/mbrd_ctrl.sv
module mbrd_ctrl
  import mbrd_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqSel,
  input  logic    reqAddrLsb,
  output seqCtl_t ctl,
  output logic    busy,
  output logic    done,
  output logic    addrErr,
  output logic    strobeN,
  output logic    memOwn
);

  seqState_t state, stateNext;
  logic      badAddr;
  logic      errQ;

  assign badAddr = !reqSel && reqAddrLsb;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:    if (reqValid && !badAddr) stateNext = ST_ALO;
      ST_ALO:     stateNext = ST_ALO_STB;
      ST_ALO_STB: stateNext = ST_AHI;
      ST_AHI:     stateNext = ST_AHI_STB;
      ST_AHI_STB: stateNext = ST_TURN;
      ST_TURN:    stateNext = ST_DLO;
      ST_DLO:     stateNext = ST_DSTB;
      ST_DSTB:    stateNext = ST_DHI;
      ST_DHI:     stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      errQ  <= 1'b0;
    end else begin
      state <= stateNext;
      errQ  <= (state == ST_IDLE) && reqValid && badAddr;
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.loadReq    = (state == ST_IDLE) && reqValid && !badAddr;
    ctl.driveBus   = (state == ST_ALO) || (state == ST_ALO_STB) ||
                     (state == ST_AHI) || (state == ST_AHI_STB);
    ctl.addrHi     = (state == ST_AHI) || (state == ST_AHI_STB);
    ctl.capLane[0] = (state == ST_DLO);
    ctl.capLane[1] = (state == ST_DHI);
  end

  assign strobeN = !((state == ST_ALO_STB) || (state == ST_AHI_STB) ||
                     (state == ST_DSTB));
  assign memOwn  = (state == ST_TURN) || (state == ST_DLO) ||
                   (state == ST_DSTB) || (state == ST_DHI);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_DONE);
  assign addrErr = errQ;

endmodule

// File: rtl/mbrd_dp.sv
module mbrd_dp
  import mbrd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqCtl_t             ctl,
  input  logic [2*BYTE_W-1:0] reqAddr,
  input  logic                reqSel,
  input  logic [BYTE_W-1:0]   busIn,
  output logic [BYTE_W-1:0]   busOut,
  output logic                busOe,
  output logic                selQ,
  output logic [2*BYTE_W-1:0] rdData
);

  localparam int LANES  = 2;
  localparam int WORD_W = LANES * BYTE_W;

  logic [WORD_W-1:0] addrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      selQ  <= 1'b0;
    end else if (ctl.loadReq) begin
      addrQ <= reqAddr;
      selQ  <= reqSel;
    end
  end

  assign busOut = ctl.addrHi ? addrQ[WORD_W-1:BYTE_W] : addrQ[BYTE_W-1:0];
  assign busOe  = ctl.driveBus;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [BYTE_W-1:0] laneQ;
    always_ff @(posedge clk) begin
      if (!rstN) laneQ <= '0;
      else if (ctl.capLane[g]) laneQ <= busIn;
    end
    assign rdData[g*BYTE_W +: BYTE_W] = laneQ;
  end

endmodule

// File: rtl/mbus_read_seq.sv
module mbus_read_seq
  import mbrd_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [WORD_W-1:0] reqAddr,
  input  logic              reqSel,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdData,
  output logic              addrErr,
  output logic [BYTE_W-1:0] busOut,
  output logic              busOe,
  input  logic [BYTE_W-1:0] busIn,
  output logic              memOwn,
  output logic              ptrSel,
  output logic              strobeN
);

  seqCtl_t ctl;
  logic    selQ;

  mbrd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqSel     (reqSel),
    .reqAddrLsb (reqAddr[0]),
    .ctl        (ctl),
    .busy       (busy),
    .done       (done),
    .addrErr    (addrErr),
    .strobeN    (strobeN),
    .memOwn     (memOwn)
  );

  mbrd_dp #(.BYTE_W(BYTE_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .reqAddr (reqAddr),
    .reqSel  (reqSel),
    .busIn   (busIn),
    .busOut  (busOut),
    .busOe   (busOe),
    .selQ    (selQ),
    .rdData  (rdData)
  );

  assign ptrSel = busy && selQ;

endmodule

// File: rtl/mbus_read_seq_chk.sv
module mbus_read_seq_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic addrErr,
  input logic busOe,
  input logic memOwn,
  input logic ptrSel,
  input logic strobeN
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (strobeN && !busOe && !memOwn && !ptrSel));

  // R4
  own_vs_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> !memOwn);

  // R2
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

  // R5
  own_after_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOwn) |-> (!$past(strobeN) && strobeN));

  // R6
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobeN |=> strobeN);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  err_no_transfer_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrErr |-> (!busy && strobeN));

  // R10
  release_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!memOwn && !busy));

endmodule

bind mbus_read_seq mbus_read_seq_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busy    (busy),
  .done    (done),
  .addrErr (addrErr),
  .busOe   (busOe),
  .memOwn  (memOwn),
  .ptrSel  (ptrSel),
  .strobeN (strobeN)
);

// File: tb/mbus_read_seq_tb.sv
module mbus_read_seq_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqSel = 1'b0;
  logic        busy, done, addrErr, busOe, memOwn, ptrSel, strobeN;
  logic [15:0] rdData;
  logic [7:0]  busOut, busIn;

  always #10 clk = ~clk;

  mbus_read_seq u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqSel(reqSel), .busy(busy), .done(done), .rdData(rdData),
    .addrErr(addrErr), .busOut(busOut), .busOe(busOe), .busIn(busIn),
    .memOwn(memOwn), .ptrSel(ptrSel), .strobeN(strobeN)
  );

  int nChecks = 0;
  int nFail   = 0;
  int cyc     = 0;
  int stbCnt  = 0;
  logic prevOwn = 1'b0;
  logic finished = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] memWord(logic [15:0] a, logic s);
    return s ? (a * 16'd7 + 16'h1234) : (a ^ 16'hA5C3);
  endfunction

  // memory model: junk byte unless it owns the bus; high byte only after a strobe
  logic [7:0] mLo = '0, mHi = '0;
  logic       mPhase = 1'b0, mHalf = 1'b0, mPtr = 1'b0;
  logic [15:0] mWord;
  always @(posedge clk) begin
    if (!rstN) begin
      mPhase <= 1'b0; mHalf <= 1'b0;
    end else begin
      if (memOwn) mPhase <= 1'b0;
      if (!strobeN && !memOwn) begin
        if (!mPhase) mLo <= busOut; else mHi <= busOut;
        mPhase <= ~mPhase;
        mPtr   <= ptrSel;
      end
      if (!memOwn) mHalf <= 1'b0;
      else if (!strobeN) mHalf <= 1'b1;
    end
  end
  always_comb begin
    mWord = memWord({mHi, mLo}, mPtr);
    busIn = memOwn ? (mHalf ? mWord[15:8] : mWord[7:0]) : 8'hEE;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  typedef struct {
    logic [15:0] addr;
    logic        sel;
    logic [15:0] data;
    int          cycReq;
  } item_t;
  item_t sbq[$];

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (!strobeN) stbCnt++;
      if (busOe) chk("R4 memOwn low while driving", {31'd0, memOwn}, 32'd0);
      if (memOwn && !prevOwn) begin
        chk("R5 busOe off at hand-over", {31'd0, busOe}, 32'd0);
        chk("R5 no strobe in turnaround", {31'd0, strobeN}, 32'd1);
      end
      if (sbq.size() != 0 && cyc > sbq[0].cycReq) begin
        chk("R2 busy during transfer", {31'd0, busy}, 32'd1);
        chk("R3 pointer select", {31'd0, ptrSel}, {31'd0, sbq[0].sel});
      end
      if (done) begin
        if (sbq.size() == 0) begin
          chk("R9 unexpected done", 32'd1, 32'd0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk("R7 read data", {16'd0, rdData}, {16'd0, it.data});
          chk("R7 done timing", cyc, it.cycReq + 9);
          chk("R4 address bytes seen by memory", {16'd0, mHi, mLo}, {16'd0, it.addr});
          chk("R3 pointer seen by memory", {31'd0, mPtr}, {31'd0, it.sel});
          chk("R6 three strobes", stbCnt, 32'd3);
        end
        stbCnt = 0;
      end
      prevOwn = memOwn;
    end
  end

  // driver
  task automatic doRead(logic [15:0] a, logic s, bit interfere);
    item_t it;
    @(negedge clk);
    reqAddr = a; reqSel = s; reqValid = 1'b1;
    it.addr = a; it.sel = s; it.data = memWord(a, s); it.cycReq = cyc;
    sbq.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
    if (interfere) begin
      repeat (2) @(negedge clk);
      reqAddr = 16'h4444; reqSel = 1'b1; reqValid = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
    end
    while (sbq.size() != 0) @(negedge clk);
    // R10
    @(negedge clk);
    chk("R10 memOwn low after done", {31'd0, memOwn}, 32'd0);
    chk("R10 idle after done", {31'd0, busy}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R7 data held", {16'd0, rdData}, {16'd0, memWord(a, s)});
    if (interfere) chk("R9 no second transfer", {31'd0, busy}, 32'd0);
  endtask

  task automatic oddReject(logic [15:0] a);
    @(negedge clk);
    reqAddr = a; reqSel = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk("R8 addrErr pulse", {31'd0, addrErr}, 32'd1);
    chk("R8 no busy", {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk("R8 addrErr single cycle", {31'd0, addrErr}, 32'd0);
    chk("R8 no transfer", {31'd0, busy}, 32'd0);
    chk("R8 no strobe", {31'd0, strobeN}, 32'd1);
    chk("R8 no ownership change", {31'd0, memOwn}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk("R1 strobe idle high", {31'd0, strobeN}, 32'd1);
    chk("R1 memOwn low", {31'd0, memOwn}, 32'd0);
    chk("R1 busOe low", {31'd0, busOe}, 32'd0);
    chk("R1 busy low", {31'd0, busy}, 32'd0);
    chk("R1 ptrSel low", {31'd0, ptrSel}, 32'd0);
    chk("R1 done low", {31'd0, done}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    doRead(16'h1234, 1'b0, 1'b0);
    doRead(16'hBEEE, 1'b0, 1'b0);
    doRead(16'h0000, 1'b1, 1'b0);
    doRead(16'hFFFF, 1'b1, 1'b0);   // R8 odd allowed on program pointer
    oddReject(16'h0011);
    doRead(16'h7F02, 1'b0, 1'b1);   // R9 request during transfer
    oddReject(16'hFFFF);
    doRead(16'h5A5A, 1'b0, 1'b0);
    chk("R2 scoreboard drained", sbq.size(), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule